// File: doc/BRIEF.md
# MD4 Block Compression Engine

This block applies the MD4 compression function to one 512-bit message block that has already been padded. It works one step per clock. On an accepted start it copies the current 128-bit chaining state, which is either the fixed initial value or the result of the previous block. It then runs 48 update steps grouped as three rounds of sixteen. Finally it adds the copied state back in, word by word, to form the new chaining state.

A caller hashes a single-block message by pulsing `start` with `init_iv` high. A multi-block message continues by pulsing `start` with `init_iv` low for each following block. The result is presented as a 128-bit byte string. Padding, the comparison against a target hash and candidate-word handling belong to the surrounding logic.

Top module: `md4_core`

## Requirements
- R1: After reset `busy` and `done` are low. `digest` equals 128'h0123456789abcdeffedcba9876543210, which is the initial chaining words A=67452301, B=EFCDAB89, C=98BADCFE, D=10325476 in the byte order of R2.
- R2: A `start` accepted with `init_iv` high hashes `blk_in` from the initial chaining words. Message word k is `blk_in[32k+31:32k]`. `digest[127:120]` carries the low byte of A, the bytes then run through A, B and C, and `digest[7:0]` carries the high byte of D. The padded empty message (word 0 = 0x00000080, all others zero) gives 31d6cfe0d16ae931b73c59d7e0c089c0. The padded "abc" (word 0 = 0x80636261, word 14 = 0x18) gives a448017aaf21d8525fc10ae87aa6729d.
- R3: A `start` accepted with `init_iv` low starts from the chaining state left by the previous result.
- R4: A `start` is accepted when `busy` is low. `busy` is then high for exactly 48 cycles. `done` is high for one cycle after the 48th rising edge following the accepting edge, and `busy` is low in that cycle.
- R5: `blk_in` is captured on the accepting edge. Changes to it while `busy` is high have no effect on the result.
- R6: A `start` while `busy` is high is ignored. It neither restarts the step count, changes the result, nor produces an extra `done`.
- R7: `digest` holds the previous result until the cycle in which `done` is high.
- R8: Each step replaces one word (the order is A, D, C, B, repeating) with rotl(word + F(other three) + X[k] + K, s). F is (x&y)|(~x&z) in round 1, majority in round 2 and x^y^z in round 3. K is 0, 0x5A827999 and 0x6ED9EBA1 for the three rounds. The message order is natural in round 1, 0,4,8,12,1,... in round 2, and 4-bit bit-reversed in round 3. The rotates are {3,7,11,19}, {3,5,9,13} and {3,9,11,15}. For any block the result matches this definition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to compress `blk_in` |
| init_iv | input | 1 | With `start`: begin from the initial value instead of the last result |
| blk_in | input | 512 | Sixteen 32-bit message words, word k at bits 32k+31:32k |
| busy | output | 1 | Compression in progress |
| done | output | 1 | One-cycle pulse when a new digest is ready |
| digest | output | 128 | Chaining state as a byte string, first byte in the top bits |

## Verification
The bench checks the two published single-block vectors and then chained blocks against its own step model. A mistake in any round function, constant, message order or rotate would change every digest, and a design that skipped the final addition or used the wrong starting state on chaining would fail the multi-block jobs. Some jobs overwrite `blk_in` in mid-run or pulse `start` again while busy. A design that read the live input or restarted would produce a wrong digest, a late `done` or an unexpected second `done`. The exact `done` cycle and the held `digest` during a run are sampled as well, so an off-by-one step counter or an early write of the chaining state is caught.

// File: rtl/md4_pkg.sv
package md4_pkg;
  localparam int WORD_W    = 32;
  localparam int MSG_WORDS = 16;
  localparam int ROUNDS    = 3;
  localparam int STEPS     = ROUNDS * MSG_WORDS;
  localparam int QUAD      = 4;
  localparam int BLK_W     = WORD_W * MSG_WORDS;
  localparam int DIG_W     = WORD_W * QUAD;
  localparam int POS_W     = $clog2(MSG_WORDS);
  localparam int STEP_W    = $clog2(STEPS);
  localparam int RND_W     = STEP_W - POS_W;
  localparam int ROT_W     = $clog2(WORD_W);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [RND_W-1:0]  rnd_t;
  typedef logic [POS_W-1:0]  pos_t;
  typedef logic [ROT_W-1:0]  rot_t;
  typedef struct packed { word_t a; word_t b; word_t c; word_t d; } quad_t;

  localparam quad_t IV = '{a: 32'h67452301, b: 32'hEFCDAB89,
                           c: 32'h98BADCFE, d: 32'h10325476};

  // Round-dependent auxiliary function
  function automatic word_t mix(rnd_t r, word_t x, word_t y, word_t z);
    case (r)
      2'd0:    return (x & y) | (~x & z);
      2'd1:    return (x & y) | (x & z) | (y & z);
      default: return x ^ y ^ z;
    endcase
  endfunction

  function automatic word_t rotl(word_t v, rot_t s);
    return (v << s) | (v >> (WORD_W - int'(s)));
  endfunction

  // Message word selected at position p of round r
  function automatic pos_t msg_index(rnd_t r, pos_t p);
    case (r)
      2'd0:    return p;
      2'd1:    return {p[1:0], p[3:2]};
      default: return {p[0], p[1], p[2], p[3]};
    endcase
  endfunction

  function automatic rot_t rot_amount(rnd_t r, pos_t p);
    case (r)
      2'd0: case (p[1:0])
              2'd0: return 5'd3;  2'd1: return 5'd7;
              2'd2: return 5'd11; default: return 5'd19;
            endcase
      2'd1: case (p[1:0])
              2'd0: return 5'd3;  2'd1: return 5'd5;
              2'd2: return 5'd9;  default: return 5'd13;
            endcase
      default: case (p[1:0])
              2'd0: return 5'd3;  2'd1: return 5'd9;
              2'd2: return 5'd11; default: return 5'd15;
            endcase
    endcase
  endfunction

  function automatic word_t round_const(rnd_t r);
    case (r)
      2'd0:    return 32'h0;
      2'd1:    return 32'h5A827999;
      default: return 32'h6ED9EBA1;
    endcase
  endfunction

  function automatic quad_t add_quad(quad_t x, quad_t y);
    return '{a: x.a + y.a, b: x.b + y.b, c: x.c + y.c, d: x.d + y.d};
  endfunction
endpackage

// File: rtl/md4_ctrl.sv
module md4_ctrl
  import md4_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              accept,
  output logic              busy,
  output logic              last_step,
  output logic              done,
  output logic [STEP_W-1:0] step_idx
);
  logic running;

  assign accept    = start && !running;
  assign last_step = running && (step_idx == STEP_W'(STEPS - 1));
  assign busy      = running;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= 1'b0;
      step_idx <= '0;
      done     <= 1'b0;
    end else begin
      done <= last_step;
      if (accept) begin
        running  <= 1'b1;
        step_idx <= '0;
      end else if (running) begin
        if (last_step) begin
          running  <= 1'b0;
          step_idx <= '0;
        end else begin
          step_idx <= step_idx + STEP_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/md4_sched.sv
module md4_sched
  import md4_pkg::*;
(
  input  logic [STEP_W-1:0] step_idx,
  output rnd_t              rnd,
  output pos_t              msg_sel,
  output rot_t              rot_amt,
  output word_t             k_word
);
  pos_t pos;

  assign pos     = step_idx[POS_W-1:0];
  assign rnd     = step_idx[STEP_W-1:POS_W];
  assign msg_sel = msg_index(rnd, pos);
  assign rot_amt = rot_amount(rnd, pos);
  assign k_word  = round_const(rnd);
endmodule

// File: rtl/md4_step.sv
module md4_step
  import md4_pkg::*;
(
  input  quad_t cur,
  input  word_t x_word,
  input  word_t k_word,
  input  rnd_t  rnd,
  input  rot_t  rot_amt,
  output word_t fresh,
  output quad_t nxt
);
  word_t sum;

  // Update slot a, then rotate roles so the next target lands in slot a
  always_comb begin
    sum   = cur.a + mix(rnd, cur.b, cur.c, cur.d) + x_word + k_word;
    fresh = rotl(sum, rot_amt);
    nxt   = '{a: cur.d, b: fresh, c: cur.b, d: cur.c};
  end
endmodule

// File: rtl/md4_core.sv
module md4_core
  import md4_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             init_iv,
  input  logic [BLK_W-1:0] blk_in,
  output logic             busy,
  output logic             done,
  output logic [DIG_W-1:0] digest
);
  localparam int BYTES_PER_WORD = WORD_W / 8;

  logic              accept;
  logic              last_step;
  logic [STEP_W-1:0] step_idx;
  rnd_t              rnd;
  pos_t              msg_sel;
  rot_t              rot_amt;
  word_t             k_word;
  word_t             x_word;
  word_t             fresh;
  quad_t             work_q, saved_q, chain_q, nxt, base;
  logic [BLK_W-1:0]  blk_q;
  word_t             blk_w   [MSG_WORDS];
  word_t             chain_w [QUAD];

  md4_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept), .busy(busy),
    .last_step(last_step), .done(done), .step_idx(step_idx)
  );

  md4_sched u_sched (
    .step_idx(step_idx), .rnd(rnd), .msg_sel(msg_sel),
    .rot_amt(rot_amt), .k_word(k_word)
  );

  for (genvar k = 0; k < MSG_WORDS; k++) begin : g_msg
    assign blk_w[k] = blk_q[k*WORD_W +: WORD_W];
  end
  assign x_word = blk_w[msg_sel];

  md4_step u_step (
    .cur(work_q), .x_word(x_word), .k_word(k_word), .rnd(rnd),
    .rot_amt(rot_amt), .fresh(fresh), .nxt(nxt)
  );

  assign base = init_iv ? IV : chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      work_q  <= IV;
      saved_q <= IV;
      chain_q <= IV;
      blk_q   <= '0;
    end else if (accept) begin
      work_q  <= base;
      saved_q <= base;
      blk_q   <= blk_in;
    end else if (busy) begin
      work_q <= nxt;
      if (last_step) chain_q <= add_quad(saved_q, nxt);
    end
  end

  // Little-endian byte string: low byte of A first, high byte of D last
  assign chain_w[0] = chain_q.a;
  assign chain_w[1] = chain_q.b;
  assign chain_w[2] = chain_q.c;
  assign chain_w[3] = chain_q.d;
  for (genvar w = 0; w < QUAD; w++) begin : g_word
    for (genvar b = 0; b < BYTES_PER_WORD; b++) begin : g_byte
      assign digest[DIG_W-1-(w*WORD_W+b*8) -: 8] = chain_w[w][b*8 +: 8];
    end
  end
endmodule

// File: rtl/md4_core_chk.sv
module md4_core_chk
  import md4_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              accept,
  input logic              last_step,
  input logic [STEP_W-1:0] step_idx,
  input logic [DIG_W-1:0]  digest
);
  localparam int CNT_W = STEP_W + 1;
  logic [CNT_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + CNT_W'(1);
    else           run_cnt <= '0;
  end

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_accept_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);
  assert_last_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> (done && !busy));
  assert_run_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && run_cnt == CNT_W'(STEPS)));
  assert_no_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last_step) |=> (step_idx == $past(step_idx) + STEP_W'(1)));
  assert_digest_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(digest));
endmodule

bind md4_core md4_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .accept(accept), .last_step(last_step), .step_idx(step_idx), .digest(digest)
);

// File: tb/sim_md4_core.sv
module sim_md4_core;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         init_iv = 1'b0;
  logic [511:0] blk_in = '0;
  logic         busy, done;
  logic [127:0] digest;

  always #10 clk = ~clk;

  md4_core u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .init_iv(init_iv),
    .blk_in(blk_in), .busy(busy), .done(done), .digest(digest)
  );

  localparam logic [127:0] IV_WORDS = 128'h67452301_EFCDAB89_98BADCFE_10325476;

  int           checks = 0;
  int           errors = 0;
  bit           finished = 0;
  logic [127:0] exp_q[$];
  string        tag_q[$];
  logic [127:0] cv = IV_WORDS;
  logic [127:0] mon_exp;
  string        mon_tag;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] bswap(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  function automatic logic [127:0] to_digest(input logic [127:0] w);
    return {bswap(w[127:96]), bswap(w[95:64]), bswap(w[63:32]), bswap(w[31:0])};
  endfunction

  // Independent step model: explicit target word per step, R8
  function automatic logic [127:0] ref_md4(input logic [127:0] cvin, input logic [511:0] m);
    logic [31:0] w [4];
    logic [31:0] x, y, z, t, fv, k;
    int idx, s, tg, r, i;
    w[0] = cvin[127:96]; w[1] = cvin[95:64]; w[2] = cvin[63:32]; w[3] = cvin[31:0];
    for (int j = 0; j < 48; j++) begin
      r  = j / 16;
      i  = j % 16;
      tg = (4 - (j % 4)) % 4;
      x  = w[(tg + 1) % 4];
      y  = w[(tg + 2) % 4];
      z  = w[(tg + 3) % 4];
      if (r == 0) begin
        fv = (x & y) | (~x & z); k = 32'h0; idx = i;
        s = (i % 4 == 0) ? 3 : (i % 4 == 1) ? 7 : (i % 4 == 2) ? 11 : 19;
      end else if (r == 1) begin
        fv = (x & y) | (x & z) | (y & z); k = 32'h5A827999; idx = (i % 4) * 4 + i / 4;
        s = (i % 4 == 0) ? 3 : (i % 4 == 1) ? 5 : (i % 4 == 2) ? 9 : 13;
      end else begin
        fv = x ^ y ^ z; k = 32'h6ED9EBA1;
        idx = (i % 2) * 8 + ((i / 2) % 2) * 4 + ((i / 4) % 2) * 2 + (i / 8);
        s = (i % 4 == 0) ? 3 : (i % 4 == 1) ? 9 : (i % 4 == 2) ? 11 : 15;
      end
      t = w[tg] + fv + m[idx*32 +: 32] + k;
      w[tg] = (t << s) | (t >> (32 - s));
    end
    return {w[0] + cvin[127:96], w[1] + cvin[95:64], w[2] + cvin[63:32], w[3] + cvin[31:0]};
  endfunction

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R6", "unexpected done", digest, '0);
      end else begin
        mon_exp = exp_q.pop_front();
        mon_tag = tag_q.pop_front();
        check(digest === mon_exp, mon_tag, "digest", digest, mon_exp);
      end
    end
  end

  // Driver: pushes the expected digest, runs one job, optionally disturbs it
  task automatic run_job(input bit ini, input logic [511:0] blk, input bit use_lit,
                         input logic [127:0] lit, input bit dist_blk, input bit dist_start,
                         input string req);
    logic [127:0] base, nw, prev;
    int n;
    base = ini ? IV_WORDS : cv;
    nw   = ref_md4(base, blk);
    exp_q.push_back(use_lit ? lit : to_digest(nw));
    tag_q.push_back(req);
    prev = digest;
    @(negedge clk);
    start = 1'b1; init_iv = ini; blk_in = blk;
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        start = 1'b0;
        check(busy === 1'b1, "R4", "busy after accept", 128'(busy), 128'd1);
      end
      if (dist_blk && n == 10) blk_in = ~blk;                 // R5
      if (dist_start && n == 20) begin                         // R6
        start = 1'b1; init_iv = ~ini; blk_in = ~blk;
      end
      if (n == 21) start = 1'b0;
      if (n == 24) check(digest === prev, "R7", "digest held mid-run", digest, prev);
      if (done || n >= 100) break;
    end
    check(n == 49, "R4", "done latency", 128'(n), 128'd49);
    check(busy === 1'b0, "R4", "busy low with done", 128'(busy), 128'd0);
    cv = nw;
    init_iv = 1'b0;
  endtask

  function automatic logic [511:0] rnd_block();
    logic [511:0] b;
    for (int k = 0; k < 16; k++) b[k*32 +: 32] = $urandom;
    return b;
  endfunction

  initial begin
    logic [511:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(done === 1'b0, "R1", "done after reset", 128'(done), 128'd0);
    check(busy === 1'b0, "R1", "busy after reset", 128'(busy), 128'd0);
    check(digest === 128'h0123456789abcdeffedcba9876543210, "R1", "digest after reset",
          digest, 128'h0123456789abcdeffedcba9876543210);

    b = '0; b[31:0] = 32'h00000080;
    run_job(1'b1, b, 1'b1, 128'h31d6cfe0d16ae931b73c59d7e0c089c0, 1'b0, 1'b0, "R2");
    b = '0; b[31:0] = 32'h80636261; b[14*32 +: 32] = 32'h18;
    run_job(1'b1, b, 1'b1, 128'ha448017aaf21d8525fc10ae87aa6729d, 1'b1, 1'b0, "R2");
    run_job(1'b0, rnd_block(), 1'b0, '0, 1'b0, 1'b1, "R3");
    run_job(1'b0, rnd_block(), 1'b0, '0, 1'b1, 1'b1, "R3");
    for (int j = 0; j < 6; j++)
      run_job(j[0], rnd_block(), 1'b0, '0, j[1], j[2], "R8");
    b = '1;
    run_job(1'b1, b, 1'b0, '0, 1'b0, 1'b0, "R8");

    repeat (60) @(negedge clk);
    check(exp_q.size() == 0, "R4", "pending results", 128'(exp_q.size()), 128'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule